// File: doc/BRIEF.md
# Banked GPIO Controller with Masked Half-Bank Writes

This block is a memory-mapped general purpose I/O controller. Its pins are arranged in banks of 32. A simple 32-bit register bus with separate read and write strobes reaches the banks. Each bank holds these registers:

- an output value register;
- a direction register;
- an output-enable register;
- a read-only view of the pin levels, taken through a two-flop synchronizer.

The block drives a value and a tri-state enable onto every pin. A pin drives actively only when it is set as an output and also enabled.

Each bank also has two masked-write registers, one for each 16-pin half of the bank. The upper 16 bits of the written word are an active-low mask. The lower 16 bits are the new pin values. Software can therefore set or clear any chosen subset of pins in one bus write, with no read-modify-write and no risk of racing another agent that touches other pins. One bank can be built with fewer than 32 pins. The missing pins read as zero and never drive.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: Reset clears every output value, direction and enable bit. While reset is held, and in the cycle after it, `pin_out` and `pin_oe` are all zero. Register reads after reset return 0.
- R2: Pin p belongs to bank p>>5 at bit p%32. `pin_out[p]` equals that bit of the bank's output value register.
- R3: The output value register of bank b sits at byte offset 0x040+4·b. A write replaces all of its bits, and a read returns the stored value.
- R4: The low masked-write register of bank b sits at 0x000+8·b. For each i in 0..15, when wdata[16+i] is 0, output bit i takes wdata[i]. When wdata[16+i] is 1, bit i keeps its value. Bits 31:16 of the bank never change. A read of this offset returns 0.
- R5: The high masked-write register of bank b sits at 0x004+8·b. It applies the same rule to output bits 16+i, and bits 15:0 never change.
- R6: The direction register sits at 0x204+0x40·b and the enable register at 0x208+0x40·b. Both read back. `pin_oe[p]` is 1 only when the pin's direction bit (1 = output) and its enable bit are both 1.
- R7: The input view of bank b sits at 0x060+4·b. A level change on `pin_in` is returned by a read whose strobe is taken on the third rising edge after the change; reads on the first two edges still return the old level. Writes to this offset change nothing.
- R8: With the defaults, bank 1 implements only pins 21:0. Its bits 31:22 read as 0 in every register, ignore writes, and never drive `pin_out` or `pin_oe`.
- R9: Unmapped offsets read as 0 and ignore writes. Unmapped offsets include any offset with addr[1:0] not 0, banks beyond NUM_BANKS, and gaps in the configuration region.
- R10: `bus_rdata` loads on the rising edge that samples `bus_rd` and holds while `bus_rd` is low. A read and a write of the same register in one cycle returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | 128 | Sampled pin levels |
| pin_out | output | 128 | Per-pin output value |
| pin_oe | output | 128 | Per-pin drive enable (0 = tri-state) |

## Verification
A register write takes effect on the edge that samples the strobe, so `pin_out` and `pin_oe` are due one edge after a write. The bench drives every strobe on a falling edge and samples the pins on the next falling edge. Read data is due one edge after the read strobe, and the bench reads it at the following falling edge. The input path adds two synchronizer edges. The bench therefore holds a read strobe across three consecutive edges after a pin change, expecting the old level twice and the new level on the third. A combined read and write in one cycle is checked for the old value, followed by a separate read for the new one.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int BANK_W   = 32;
  localparam int HALF_W   = 16;
  localparam int BANK_IDX = 3;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_MASK,
    REG_DATA,
    REG_INPUT,
    REG_DIR,
    REG_OEN
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e             kind;
    logic [BANK_IDX-1:0]   bank;
    logic                  half;
  } reg_sel_t;

  // Bits a bank really implements: all 32, or the low short_pins for the short bank.
  function automatic logic [BANK_W-1:0] impl_mask(input int bank, input int short_bank,
                                                  input int short_pins);
    logic [BANK_W:0] t;
    if (bank == short_bank) begin
      t = (33'd1 << short_pins) - 33'd1;
      return t[BANK_W-1:0];
    end
    return '1;
  endfunction

  // Masked half-bank update: mask bits 31:16 are active low, values in 15:0.
  function automatic logic [BANK_W-1:0] merge_masked(input logic [BANK_W-1:0] old_v,
                                                     input logic [BANK_W-1:0] word,
                                                     input logic half);
    logic [BANK_W-1:0] en;
    logic [BANK_W-1:0] val;
    en  = half ? {~word[31:16], 16'h0000} : {16'h0000, ~word[31:16]};
    val = half ? {word[15:0], 16'h0000}   : {16'h0000, word[15:0]};
    return (old_v & ~en) | (val & en);
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);

  localparam logic [31:0] MASK_END = 32'(8 * NUM_BANKS);
  localparam logic [31:0] DATA_BEG = 32'h040;
  localparam logic [31:0] DATA_END = DATA_BEG + 32'(4 * NUM_BANKS);
  localparam logic [31:0] IN_BEG   = 32'h060;
  localparam logic [31:0] IN_END   = IN_BEG + 32'(4 * NUM_BANKS);
  localparam logic [31:0] CFG_BEG  = 32'h200;
  localparam logic [31:0] CFG_END  = CFG_BEG + 32'(64 * NUM_BANKS);

  logic [31:0] a32;
  assign a32 = 32'(addr);

  always_comb begin
    sel.kind = REG_NONE;
    sel.bank = '0;
    sel.half = 1'b0;
    if (a32[1:0] == 2'b00) begin
      if (a32 < MASK_END) begin
        sel.kind = REG_MASK;
        sel.bank = a32[5:3];
        sel.half = a32[2];
      end else if (a32 >= DATA_BEG && a32 < DATA_END) begin
        sel.kind = REG_DATA;
        sel.bank = a32[4:2];
      end else if (a32 >= IN_BEG && a32 < IN_END) begin
        sel.kind = REG_INPUT;
        sel.bank = a32[4:2];
      end else if (a32 >= CFG_BEG && a32 < CFG_END) begin
        sel.bank = a32[8:6];
        if (a32[5:0] == 6'h04)      sel.kind = REG_DIR;
        else if (a32[5:0] == 6'h08) sel.kind = REG_OEN;
      end
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter logic [BANK_W-1:0] IMPL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mask,
  input  logic              wr_data,
  input  logic              wr_dir,
  input  logic              wr_oen,
  input  logic              half,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] data_q,
  output logic [BANK_W-1:0] dir_q,
  output logic [BANK_W-1:0] oen_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      oen_q  <= '0;
    end else begin
      if (wr_mask)      data_q <= merge_masked(data_q, wdata, half) & IMPL;
      else if (wr_data) data_q <= wdata & IMPL;
      if (wr_dir)       dir_q  <= wdata & IMPL;
      if (wr_oen)       oen_q  <= wdata & IMPL;
    end
  end

endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int ADDR_W     = 12,
  parameter int SHORT_BANK = 1,
  parameter int SHORT_PINS = 22,
  parameter int NPINS      = BANK_W * NUM_BANKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);

  reg_sel_t dec_sel;

  // Named write events, visible to the bound checker.
  logic evt_wr_mask, evt_wr_data, evt_wr_dir, evt_wr_oen;

  logic [BANK_W-1:0] data_q  [NUM_BANKS];
  logic [BANK_W-1:0] dir_q   [NUM_BANKS];
  logic [BANK_W-1:0] oen_q   [NUM_BANKS];
  logic [BANK_W-1:0] in_view [NUM_BANKS];
  logic [NPINS-1:0]  sync_q;
  logic [31:0]       rd_mux;

  gpio_addr_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (dec_sel)
  );

  assign evt_wr_mask = bus_wr && (dec_sel.kind == REG_MASK);
  assign evt_wr_data = bus_wr && (dec_sel.kind == REG_DATA);
  assign evt_wr_dir  = bus_wr && (dec_sel.kind == REG_DIR);
  assign evt_wr_oen  = bus_wr && (dec_sel.kind == REG_OEN);

  gpio_in_sync #(.WIDTH(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (sync_q)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [BANK_W-1:0] IMPL = impl_mask(b, SHORT_BANK, SHORT_PINS);
    logic hit;
    assign hit = (dec_sel.bank == BANK_IDX'(b));

    gpio_bank #(.IMPL(IMPL)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_mask (evt_wr_mask && hit),
      .wr_data (evt_wr_data && hit),
      .wr_dir  (evt_wr_dir && hit),
      .wr_oen  (evt_wr_oen && hit),
      .half    (dec_sel.half),
      .wdata   (bus_wdata),
      .data_q  (data_q[b]),
      .dir_q   (dir_q[b]),
      .oen_q   (oen_q[b])
    );

    assign in_view[b]               = sync_q[b*BANK_W +: BANK_W] & IMPL;
    assign pin_out[b*BANK_W +: BANK_W] = data_q[b];
    assign pin_oe[b*BANK_W +: BANK_W]  = dir_q[b] & oen_q[b];
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (dec_sel.bank == BANK_IDX'(b)) begin
        case (dec_sel.kind)
          REG_DATA:  rd_mux = data_q[b];
          REG_INPUT: rd_mux = in_view[b];
          REG_DIR:   rd_mux = dir_q[b];
          REG_OEN:   rd_mux = oen_q[b];
          default:   rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/gpio_banked_ctrl_checker.sv
module gpio_banked_ctrl_checker
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int SHORT_BANK = 1,
  parameter int SHORT_PINS = 22,
  parameter int NPINS      = BANK_W * NUM_BANKS
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [15:0]      mask_bits,
  input logic [31:0]      bus_rdata,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input reg_sel_t         sel
);

  logic [NPINS-1:0] allow;
  logic [NPINS-1:0] impl_all;

  always_comb begin
    allow    = '0;
    impl_all = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      impl_all[b*BANK_W +: BANK_W] = impl_mask(b, SHORT_BANK, SHORT_PINS);
      if (sel.bank == BANK_IDX'(b))
        allow[b*BANK_W + (sel.half ? HALF_W : 0) +: HALF_W] = ~mask_bits;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (pin_out == '0 && pin_oe == '0));

  // R4 and R5: only unmasked bits of the addressed half may change
  assert_mask_confined_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel.kind == REG_MASK) |=> (((pin_out ^ $past(pin_out)) & ~$past(allow)) == '0));

  assert_input_write_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel.kind == REG_INPUT) |=> ($stable(pin_out) && $stable(pin_oe)));

  assert_unimpl_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out | pin_oe) & ~impl_all) == '0);

  assert_unmapped_write_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel.kind == REG_NONE) |=> ($stable(pin_out) && $stable(pin_oe)));

  assert_unmapped_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel.kind == REG_NONE) |=> (bus_rdata == '0));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind gpio_banked_ctrl gpio_banked_ctrl_checker #(
  .NUM_BANKS  (NUM_BANKS),
  .SHORT_BANK (SHORT_BANK),
  .SHORT_PINS (SHORT_PINS),
  .NPINS      (NPINS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .mask_bits (bus_wdata[31:16]),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .sel       (dec_sel)
);

// File: tb/gpio_banked_ctrl_test.sv
module gpio_banked_ctrl_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [127:0] pin_in = '0;
  logic [127:0] pin_out;
  logic [127:0] pin_oe;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  gpio_banked_ctrl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  // {is_read, offset, data (write value or expected read), requirement number}
  localparam int NV = 35;
  localparam logic [52:0] VECS [NV] = '{
    {1'b0, 12'h040, 32'hA5A55A5A, 8'd3},  // R3 full write
    {1'b1, 12'h040, 32'hA5A55A5A, 8'd3},  // R3 read back
    {1'b0, 12'h000, 32'hFFFE0001, 8'd4},  // R4 set bit 0 only
    {1'b1, 12'h040, 32'hA5A55A5B, 8'd4},
    {1'b0, 12'h000, 32'h00001234, 8'd4},  // R4 replace whole low half
    {1'b1, 12'h040, 32'hA5A51234, 8'd4},
    {1'b1, 12'h000, 32'h00000000, 8'd4},  // R4 masked register reads 0
    {1'b0, 12'h004, 32'h7FFF0000, 8'd5},  // R5 clear bit 31 only
    {1'b1, 12'h040, 32'h25A51234, 8'd5},
    {1'b0, 12'h004, 32'hFFFFFFFF, 8'd5},  // R5 all masked, no change
    {1'b1, 12'h040, 32'h25A51234, 8'd5},
    {1'b0, 12'h048, 32'hDEADBEEF, 8'd2},  // R2 bank 2
    {1'b1, 12'h048, 32'hDEADBEEF, 8'd2},
    {1'b1, 12'h040, 32'h25A51234, 8'd2},  // R2 bank 0 untouched
    {1'b0, 12'h044, 32'hFFFFFFFF, 8'd8},  // R8 short bank
    {1'b1, 12'h044, 32'h003FFFFF, 8'd8},
    {1'b0, 12'h00C, 32'h00000000, 8'd8},  // R8 high half of short bank
    {1'b1, 12'h044, 32'h0000FFFF, 8'd8},
    {1'b0, 12'h2C4, 32'h000000FF, 8'd6},  // R6 bank 3 direction
    {1'b0, 12'h2C8, 32'h00000F0F, 8'd6},  // R6 bank 3 enable
    {1'b1, 12'h2C4, 32'h000000FF, 8'd6},
    {1'b1, 12'h2C8, 32'h00000F0F, 8'd6},
    {1'b0, 12'h244, 32'hFFFFFFFF, 8'd8},  // R8 direction of short bank
    {1'b1, 12'h244, 32'h003FFFFF, 8'd8},
    {1'b0, 12'h100, 32'h12345678, 8'd9},  // R9 hole
    {1'b1, 12'h100, 32'h00000000, 8'd9},
    {1'b1, 12'h041, 32'h00000000, 8'd9},  // R9 misaligned
    {1'b1, 12'h050, 32'h00000000, 8'd9},  // R9 bank beyond range
    {1'b0, 12'h020, 32'h00000000, 8'd9},  // R9 past last masked register
    {1'b1, 12'h048, 32'hDEADBEEF, 8'd9},
    {1'b0, 12'h20C, 32'hFFFFFFFF, 8'd9},  // R9 config gap
    {1'b1, 12'h204, 32'h00000000, 8'd9},
    {1'b0, 12'h060, 32'hFFFFFFFF, 8'd7},  // R7 write to input view
    {1'b1, 12'h040, 32'h25A51234, 8'd7},
    {1'b1, 12'h064, 32'h00000000, 8'd7}
  };

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    check("R1 pin_out in reset", pin_out, '0);
    check("R1 pin_oe in reset", pin_oe, '0);
    rst_n = 1'b1;
    bus_read(12'h040, rd); check("R1 data after reset", rd, 0);
    bus_read(12'h2C4, rd); check("R1 dir after reset", rd, 0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i][52]) begin
        bus_read(VECS[i][51:40], rd);
        check($sformatf("R%0d vector %0d", VECS[i][7:0], i), rd, VECS[i][39:8]);
      end else begin
        bus_write(VECS[i][51:40], VECS[i][39:8]);
      end
    end

    // R2 pin mapping after the table
    check("R2 pin_out banks", pin_out, {32'h0, 32'hDEADBEEF, 32'h0000FFFF, 32'h25A51234});
    check("R2 pin 40", pin_out[40], 1'b1);
    // R6 drive needs both direction and enable
    check("R6 pin_oe", pin_oe, {32'h0000000F, 96'h0});
    bus_write(12'h248, 32'hFFFFFFFF);
    check("R6 R8 pin_oe short bank", pin_oe, {32'h0000000F, 32'h0, 32'h003FFFFF, 32'h0});

    // R7 synchronizer latency
    @(negedge clk);
    pin_in = {64'h0, 32'hFFFFFFFF, 32'hCAFEF00D};
    bus_rd = 1'b1; bus_addr = 12'h060;
    @(negedge clk); check("R7 edge 1 old level", bus_rdata, 0);
    @(negedge clk); check("R7 edge 2 old level", bus_rdata, 0);
    @(negedge clk); check("R7 edge 3 new level", bus_rdata, 32'hCAFEF00D);
    bus_rd = 1'b0;
    bus_read(12'h064, rd); check("R7 R8 short bank input", rd, 32'h003FFFFF);

    // R10 read and write in one cycle, then hold
    @(negedge clk);
    bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 12'h048; bus_wdata = 32'h11111111;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R10 read sees old value", bus_rdata, 32'hDEADBEEF);
    bus_read(12'h048, rd); check("R10 new value", rd, 32'h11111111);
    repeat (3) @(negedge clk);
    check("R10 rdata holds", bus_rdata, 32'h11111111);

    // R1 reset in mid run
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 pin_out after reset", pin_out, '0);
    check("R1 pin_oe after reset", pin_oe, '0);
    rst_n = 1'b1;
    bus_read(12'h048, rd); check("R1 data cleared", rd, 0);
    bus_read(12'h2C8, rd); check("R1 enable cleared", rd, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule